// File: doc/BRIEF.md
# Dual-Bank Ping-Pong Buffer Controller

This block connects two external processors to two external byte-wide SRAM banks. One processor only fills a buffer and the other only drains one. Neither processor ever places an address on the memory. Each bank keeps its own address pointer. The processor that currently owns a bank moves that bank's pointer with three pulse commands: step up, step down, or return to zero. A strobe from the processor then writes or reads the byte at the pointer.

The filling side and the draining side always own opposite banks. A swap request exchanges the two banks, so a buffer that has just been filled becomes the one being drained. The data path of each bank passes through two enables, one per processor, which model bus transceivers. The controller guarantees that both enables of a bank are never on together, and it leaves a one-clock dead band when ownership changes hands.

All processor inputs are asynchronous to the controller clock. Each one passes through a synchronizer before use, and the pointer commands act on their rising edge.

Top module: `pingpong_sram_ctrl`

## Requirements
- R1: After a synchronous active-low reset, both bank pointers read 0. The writer owns bank 0 and the reader owns bank 1 (bank_wr_xcvr_en = 2'b01, bank_rd_xcvr_en = 2'b10). All write and read strobes to the banks are inactive (high).
- R2: A step-up or step-down command changes only the pointer of the bank that the issuing processor owns. The other bank's pointer is left unchanged.
- R3: A zero command clears the pointer even if step-up or step-down arrives with it. Step-up and step-down arriving together leave the pointer unchanged.
- R4: The pointer wraps modulo 2^ADDR_W. Stepping down from 0 gives all ones, and stepping up from all ones gives 0.
- R5: The writer and the reader never own the same bank. The two transceiver enables of any one bank are never both high.
- R6: A swap request is held pending while either processor's strobe is active. It takes effect only after both strobes are idle.
- R7: When a swap is carried out, all transceiver enables are low for exactly one clock. After that clock, the former reader's bank is enabled for the writer and the former writer's bank is enabled for the reader.
- R8: A bank's write strobe asserts only on the bank owned by the writer, and its read strobe only on the bank owned by the reader. Write data is driven only to the writer's bank. rd_data comes from the reader's bank.
- R9: A bank's pointer is unchanged during the clock before its write or read strobe asserts. Pointer commands from a processor are ignored while that processor's strobe is active.
- R10: Each processor input passes through a SYNC_STAGES-deep synchronizer. A pointer command acts once per rising edge, however long it is held high.
- R11: Bytes written through consecutive step-up commands read back intact after a swap, both walking forward with step-up and walking backward with step-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_inc | input | 1 | Writer: step its bank's pointer up (edge) |
| wr_dec | input | 1 | Writer: step its bank's pointer down (edge) |
| wr_clr | input | 1 | Writer: return its bank's pointer to zero (edge) |
| wr_stb | input | 1 | Writer: write strobe request (level) |
| wr_data | input | DATA_W | Writer: byte to store |
| rd_inc | input | 1 | Reader: step its bank's pointer up (edge) |
| rd_dec | input | 1 | Reader: step its bank's pointer down (edge) |
| rd_clr | input | 1 | Reader: return its bank's pointer to zero (edge) |
| rd_stb | input | 1 | Reader: read strobe request (level) |
| rd_data | output | DATA_W | Reader: byte returned from its bank |
| swap_req | input | 1 | Exchange bank ownership (edge) |
| bank_addr | output | 2 x ADDR_W | Pointer of each bank, driven to its address pins |
| bank_we_n | output | 2 | Active-low write strobe per bank |
| bank_oe_n | output | 2 | Active-low output enable per bank |
| bank_wr_xcvr_en | output | 2 | Per bank: writer transceiver enable |
| bank_rd_xcvr_en | output | 2 | Per bank: reader transceiver enable |
| bank_wdata | output | 2 x DATA_W | Data driven toward each bank |
| bank_rdata | input | 2 x DATA_W | Data returned by each bank |

## Verification
The bench aims at the places where pointer arithmetic goes wrong. It checks stepping down from zero and up from all ones, and a design that wraps to the wrong value or saturates would leave a wrong pointer on the port. It sends simultaneous commands and a command held high for many clocks; a design with the wrong priority, or one that acts on level instead of edge, would step the pointer too far. It also requests a swap while the writer's strobe is held. A design that swaps at once would show new ownership mid-write, and one without the dead band would never show a clock with all enables low. A full fill, swap and drain run, both forward and reversed, shows any routing or addressing slip as a mismatched byte.

// File: rtl/pp_pkg.sv
// Package: shared constants and types for the ping-pong buffer controller.
// Assumes exactly two banks; the ping-pong scheme is defined only for a pair.
package pp_pkg;
    localparam int NUM_BANKS = 2;

    // Decoded pointer command for one bank, one clock wide.
    typedef struct packed {
        logic clr;
        logic dn;
        logic up;
    } step_cmd_t;
endpackage

// File: rtl/pp_sync.sv
// Module: multi-bit level synchronizer.
// Each bit is an independent asynchronous level; no bus coherency is assumed.
// STAGES must be at least 2.
module pp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pp_addr_ctr.sv
// Module: one bank's address pointer.
// Clear beats both steps; up and down together hold; wraps in both directions.
// Assumes command inputs are single-clock pulses already gated by ownership.
module pp_addr_ctr #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pp_pkg::step_cmd_t cmd,
    output logic [ADDR_W-1:0] addr
);
    // Update the pointer from the decoded command.
    always_ff @(posedge clk) begin
        if (!rst_n)                   addr <= '0;
        else if (cmd.clr)             addr <= '0;
        else if (cmd.up && !cmd.dn)   addr <= addr + 1'b1;
        else if (cmd.dn && !cmd.up)   addr <= addr - 1'b1;
    end

    // R3
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.clr |=> (addr == '0));
    // R3
    up_dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.up && cmd.dn && !cmd.clr) |=> $stable(addr));
    // R4
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.up && !cmd.dn && !cmd.clr && (&addr)) |=> (addr == '0));
    // R4
    wrap_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.dn && !cmd.up && !cmd.clr && (addr == '0)) |=> (&addr));
endmodule

// File: rtl/pp_own_ctrl.sv
// Module: bank ownership and swap sequencing.
// A swap request is latched and executed once no strobe is busy. It opens a
// one-clock gap with every transceiver off, then flips the writer's bank.
// The reader always owns the bank the writer does not.
module pp_own_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic swap_rise,
    input  logic busy,
    output logic wr_bank,
    output logic gap
);
    logic pending;
    logic accept;

    assign accept = pending && !busy && !gap;

    // Latch swap requests until they can be served.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending && !accept) || swap_rise;
    end

    // Run the gap clock and then flip ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= 1'b0;
            wr_bank <= 1'b0;
        end else if (gap) begin
            gap     <= 1'b0;
            wr_bank <= !wr_bank;
        end else if (accept) begin
            gap     <= 1'b1;
        end
    end

    // R6
    swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap) |-> !$past(busy));
    // R7
    gap_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap |=> !gap);
    // R7
    gap_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gap |=> (wr_bank != $past(wr_bank)));
    // R5
    owner_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gap |=> $stable(wr_bank));
endmodule

// File: rtl/pingpong_sram_ctrl.sv
// Module: dual-bank ping-pong buffer controller (top).
// Writer and reader processors step per-bank pointers with edge commands and
// strobe bytes in or out; a swap exchanges which bank each one owns.
// Assumes processor inputs are asynchronous and wr_data is stable while wr_stb
// is high. The SRAM devices themselves sit outside.
module pingpong_sram_ctrl #(
    parameter int ADDR_W      = 19,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_inc,
    input  logic                                     wr_dec,
    input  logic                                     wr_clr,
    input  logic                                     wr_stb,
    input  logic [DATA_W-1:0]                        wr_data,
    input  logic                                     rd_inc,
    input  logic                                     rd_dec,
    input  logic                                     rd_clr,
    input  logic                                     rd_stb,
    output logic [DATA_W-1:0]                        rd_data,
    input  logic                                     swap_req,
    output logic [pp_pkg::NUM_BANKS-1:0][ADDR_W-1:0] bank_addr,
    output logic [pp_pkg::NUM_BANKS-1:0]             bank_we_n,
    output logic [pp_pkg::NUM_BANKS-1:0]             bank_oe_n,
    output logic [pp_pkg::NUM_BANKS-1:0]             bank_wr_xcvr_en,
    output logic [pp_pkg::NUM_BANKS-1:0]             bank_rd_xcvr_en,
    output logic [pp_pkg::NUM_BANKS-1:0][DATA_W-1:0] bank_wdata,
    input  logic [pp_pkg::NUM_BANKS-1:0][DATA_W-1:0] bank_rdata
);
    import pp_pkg::*;

    localparam int NCMD = 7; // 3 writer cmds, 3 reader cmds, swap
    localparam int NIN  = NCMD + 2;

    logic [NIN-1:0]  in_sync;
    logic [NCMD-1:0] cmd_lvl, cmd_lvl_q, cmd_rise;
    logic            wr_lvl, rd_lvl;
    logic            wr_out, rd_out;
    logic            wr_bank, gap;
    step_cmd_t       wr_cmd, rd_cmd;

    pp_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({rd_stb, wr_stb, swap_req, rd_clr, rd_dec, rd_inc, wr_clr, wr_dec, wr_inc}),
        .dout (in_sync)
    );

    assign cmd_lvl = in_sync[NCMD-1:0];
    assign wr_lvl  = in_sync[NCMD];
    assign rd_lvl  = in_sync[NCMD+1];

    // Remember last command levels for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_lvl_q <= '0;
        else        cmd_lvl_q <= cmd_lvl;
    end

    assign cmd_rise = cmd_lvl & ~cmd_lvl_q;
    assign wr_cmd   = '{clr: cmd_rise[2], dn: cmd_rise[1], up: cmd_rise[0]};
    assign rd_cmd   = '{clr: cmd_rise[5], dn: cmd_rise[4], up: cmd_rise[3]};

    // Register the strobes one clock behind the sync so the address settles first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_out <= 1'b0;
            rd_out <= 1'b0;
        end else begin
            wr_out <= wr_lvl && !gap;
            rd_out <= rd_lvl && !gap;
        end
    end

    pp_own_ctrl u_own (
        .clk      (clk),
        .rst_n    (rst_n),
        .swap_rise(cmd_rise[6]),
        .busy     (wr_lvl || rd_lvl || wr_out || rd_out),
        .wr_bank  (wr_bank),
        .gap      (gap)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic      owner_wr;
        logic      hold;
        step_cmd_t sel_cmd;
        step_cmd_t gated;

        assign owner_wr = (wr_bank == 1'(b));
        assign sel_cmd  = owner_wr ? wr_cmd : rd_cmd;
        assign hold     = gap || (owner_wr ? wr_lvl : rd_lvl);
        assign gated    = hold ? '0 : sel_cmd;

        pp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk  (clk),
            .rst_n(rst_n),
            .cmd  (gated),
            .addr (bank_addr[b])
        );

        assign bank_wr_xcvr_en[b] = !gap && owner_wr;
        assign bank_rd_xcvr_en[b] = !gap && !owner_wr;
        assign bank_we_n[b]       = !(wr_out && bank_wr_xcvr_en[b]);
        assign bank_oe_n[b]       = !(rd_out && bank_rd_xcvr_en[b]);
        assign bank_wdata[b]      = bank_wr_xcvr_en[b] ? wr_data : '0;

        // R5
        xcvr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(bank_wr_xcvr_en[b] && bank_rd_xcvr_en[b]));
        // R8
        strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(!bank_we_n[b] && !bank_oe_n[b]));
        // R9
        we_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bank_we_n[b]) |-> $stable(bank_addr[b]));
        // R9
        oe_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bank_oe_n[b]) |-> $stable(bank_addr[b]));
    end

    // Return the byte of whichever bank the reader currently has connected.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank_rd_xcvr_en[b]) rd_data = bank_rdata[b];
    end

    // R5
    opposite_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_wr_xcvr_en) == $countones(bank_rd_xcvr_en));
endmodule

// File: tb/pingpong_sram_ctrl_tb.sv
module pingpong_sram_ctrl_tb;
    localparam int AW = 19;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_inc = 0, wr_dec = 0, wr_clr = 0, wr_stb = 0;
    logic rd_inc = 0, rd_dec = 0, rd_clr = 0, rd_stb = 0;
    logic swap_req = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [1:0][AW-1:0] bank_addr;
    logic [1:0] bank_we_n, bank_oe_n, bank_wr_xcvr_en, bank_rd_xcvr_en;
    logic [1:0][DW-1:0] bank_wdata, bank_rdata;

    int checks = 0;
    int fails  = 0;
    int overlap_cnt = 0;
    bit gap_seen = 0;
    bit done = 0;
    logic [DW-1:0] exp_q [$];
    logic [DW-1:0] mem0 [256];
    logic [DW-1:0] mem1 [256];

    always #5 clk = ~clk;

    pingpong_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_inc(wr_inc), .wr_dec(wr_dec), .wr_clr(wr_clr), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_inc(rd_inc), .rd_dec(rd_dec), .rd_clr(rd_clr), .rd_stb(rd_stb), .rd_data(rd_data),
        .swap_req(swap_req), .bank_addr(bank_addr), .bank_we_n(bank_we_n), .bank_oe_n(bank_oe_n),
        .bank_wr_xcvr_en(bank_wr_xcvr_en), .bank_rd_xcvr_en(bank_rd_xcvr_en),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata)
    );

    // SRAM models, indexed by the low address byte.
    assign bank_rdata[0] = bank_oe_n[0] ? '0 : mem0[bank_addr[0][7:0]];
    assign bank_rdata[1] = bank_oe_n[1] ? '0 : mem1[bank_addr[1][7:0]];
    always @(posedge clk) begin
        if (!bank_we_n[0]) mem0[bank_addr[0][7:0]] <= bank_wdata[0];
        if (!bank_we_n[1]) mem1[bank_addr[1][7:0]] <= bank_wdata[1];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return 8'(8'h3C + i * 29) ^ 8'h5A;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    // Pulse one or more command lines together.
    task automatic pulse(ref logic a, ref logic b, input bit use_b);
        a = 1; if (use_b) b = 1;
        tick(4);
        a = 0; if (use_b) b = 0;
        tick(4);
    endtask

    task automatic write_byte(input logic [DW-1:0] d);
        wr_data = d; wr_stb = 1;
        tick(5);
        wr_stb = 0;
        tick(4);
    endtask

    task automatic read_byte(input logic [DW-1:0] e);
        exp_q.push_back(e);
        rd_stb = 1;
        tick(5);
        rd_stb = 0;
        tick(4);
    endtask

    // Monitor: compare the first cycle of each read strobe against the queue.
    bit oe_prev = 0;
    always @(negedge clk) begin
        bit oe_act;
        oe_act = (bank_oe_n != 2'b11);
        if (rst_n && oe_act && !oe_prev) begin
            if (exp_q.size() == 0) chk(0, "R11", "unexpected read", rd_data, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R11", "read byte", rd_data, e);
            end
        end
        oe_prev = oe_act;
        if (rst_n) begin
            for (int b = 0; b < 2; b++) begin
                if (bank_wr_xcvr_en[b] && bank_rd_xcvr_en[b]) overlap_cnt++;
                if (!bank_wr_xcvr_en[b] && !bank_rd_xcvr_en[b]) gap_seen = 1;
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic dummy = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin mem0[i] = '0; mem1[i] = '0; end
        tick(4);
        rst_n = 1;
        tick(2);
        sample();
        // R1 reset state
        chk(bank_addr[0] == 0 && bank_addr[1] == 0, "R1", "pointers", bank_addr, 0);
        chk(bank_wr_xcvr_en == 2'b01 && bank_rd_xcvr_en == 2'b10, "R1", "ownership",
            {bank_wr_xcvr_en, bank_rd_xcvr_en}, 4'b0110);
        chk(bank_we_n == 2'b11 && bank_oe_n == 2'b11, "R1", "strobes",
            {bank_we_n, bank_oe_n}, 4'hF);

        // R2 writer steps only bank 0
        tick(1);
        pulse(wr_inc, dummy, 0); pulse(wr_inc, dummy, 0); pulse(wr_inc, dummy, 0);
        pulse(wr_dec, dummy, 0);
        sample();
        chk(bank_addr[0] == 2, "R2", "writer pointer", bank_addr[0], 2);
        chk(bank_addr[1] == 0, "R2", "reader pointer untouched", bank_addr[1], 0);
        tick(1);
        pulse(rd_inc, dummy, 0);
        sample();
        chk(bank_addr[1] == 1 && bank_addr[0] == 2, "R2", "reader step", bank_addr, {19'd1, 19'd2});

        // R3 priorities
        tick(1);
        pulse(wr_inc, wr_dec, 1);
        sample();
        chk(bank_addr[0] == 2, "R3", "up+down hold", bank_addr[0], 2);
        tick(1);
        pulse(wr_clr, wr_inc, 1);
        sample();
        chk(bank_addr[0] == 0, "R3", "clear beats up", bank_addr[0], 0);

        // R10 held command steps once
        tick(1);
        wr_inc = 1; tick(12); wr_inc = 0; tick(4);
        sample();
        chk(bank_addr[0] == 1, "R10", "held up steps once", bank_addr[0], 1);

        // R4 wrap both ways
        tick(1);
        pulse(wr_clr, dummy, 0);
        pulse(wr_dec, dummy, 0);
        sample();
        chk(bank_addr[0] == 19'h7FFFF, "R4", "wrap down", bank_addr[0], 19'h7FFFF);
        tick(1);
        pulse(wr_inc, dummy, 0);
        sample();
        chk(bank_addr[0] == 0, "R4", "wrap up", bank_addr[0], 0);

        // R8 routing during a write, R9 command ignored while strobing
        tick(1);
        wr_data = pat(0); wr_stb = 1;
        tick(4);
        wr_inc = 1;
        tick(4);
        sample();
        chk(bank_we_n == 2'b10 && bank_oe_n == 2'b11, "R8", "write strobe on bank 0",
            {bank_we_n, bank_oe_n}, 4'b1011);
        chk(bank_wdata[0] == pat(0) && bank_wdata[1] == 0, "R8", "write data routing",
            bank_wdata, pat(0));
        chk(bank_addr[0] == 0, "R9", "command ignored under strobe", bank_addr[0], 0);
        tick(1);
        wr_stb = 0;
        tick(4);
        wr_inc = 0;
        tick(4);
        sample();
        chk(bank_addr[0] == 0, "R9", "address after strobe", bank_addr[0], 0);
        tick(1);

        // Fill bank 0 with a pattern.
        for (int i = 0; i < 8; i++) begin
            write_byte(pat(i));
            pulse(wr_inc, dummy, 0);
        end
        sample();
        chk(bank_addr[0] == 8, "R2", "pointer after fill", bank_addr[0], 8);

        // R6 swap deferred under strobe
        tick(1);
        wr_data = 8'hEE; wr_stb = 1;
        tick(3);
        swap_req = 1; tick(4); swap_req = 0;
        tick(6);
        sample();
        chk(bank_wr_xcvr_en == 2'b01, "R6", "swap held during strobe", bank_wr_xcvr_en, 2'b01);
        chk(!gap_seen, "R6", "no gap during strobe", gap_seen, 0);
        tick(1);
        wr_stb = 0;
        tick(10);
        sample();
        // R7 new ownership and dead band
        chk(bank_wr_xcvr_en == 2'b10 && bank_rd_xcvr_en == 2'b01, "R7", "swapped ownership",
            {bank_wr_xcvr_en, bank_rd_xcvr_en}, 4'b1001);
        chk(gap_seen, "R7", "dead band observed", gap_seen, 1);

        // R11 forward and reverse read of bank 0 by the reader
        tick(1);
        pulse(rd_clr, dummy, 0);
        for (int i = 0; i < 8; i++) begin
            if (i == 0) begin
                exp_q.push_back(pat(0));
                rd_stb = 1; tick(4);
                sample();
                chk(bank_oe_n == 2'b10 && bank_we_n == 2'b11, "R8", "read strobe on bank 0",
                    {bank_we_n, bank_oe_n}, 4'b1110);
                tick(1);
                rd_stb = 0; tick(4);
            end else read_byte(pat(i));
            pulse(rd_inc, dummy, 0);
        end
        pulse(rd_dec, dummy, 0);
        for (int i = 7; i >= 0; i--) begin
            read_byte(pat(i));
            pulse(rd_dec, dummy, 0);
        end
        sample();
        chk(exp_q.size() == 0, "R11", "all reads seen", exp_q.size(), 0);
        chk(overlap_cnt == 0, "R5", "shared bank cycles", overlap_cnt, 0);
        finish_run();
    end
endmodule